// File: doc/BRIEF.md
# Relocatable PM and SMBus I/O Window Decoder

This block sits inside a PCI function's configuration space and owns two relocatable I/O windows: a 128-byte power-management window and a 16-byte SMBus window. Software places each window by writing a base register through a byte-enabled 32-bit configuration write port. Each window is switched on by a bit in a separate enable byte. Every I/O address presented to the block is decoded into a hit flag and an offset for each window.

Each base register corrects itself on every write. It keeps only the address bits at or above the window's alignment and forces bit 0, which marks I/O space, to 1. The SMBus enable byte keeps only its low nibble. A read port returns the current contents of the four configuration dwords that hold these fields. The configuration port addresses dwords: a byte offset B is reached through dword index B/4 and byte lane B%4.

Top module: `pmsmb_window_decode`

## Requirements
- R1: After a synchronous reset both base dwords read 0x00000001. The PM enable dword (index 0x10) and the SMBus enable dword (index 0x34) read zero, and neither window hits at any I/O address.
- R2: A write to dword index 0x12 (byte offset 0x48) first merges the enabled byte lanes into the PM base. The register then holds merged & 0x0000FF80, with bit 0 set.
- R3: A write to dword index 0x24 (byte offset 0x90) first merges the enabled byte lanes into the SMBus base. The register then holds merged & 0x0000FFF0, with bit 0 set.
- R4: Byte lanes whose enable is 0 keep their old contents before the correction step. A write with no lane enabled changes nothing.
- R5: The PM enable byte is byte offset 0x41, which is lane 1 of dword 0x10. It stores all 8 written bits and reads back in bits 15:8 of that dword. The PM window decodes only while its bit 7 is 1.
- R6: The SMBus enable byte is byte offset 0xD2, which is lane 2 of dword 0x34. A write to it stores only bits 3:0, and bits 7:4 read back as 0. The SMBus window decodes only while its bit 0 is 1.
- R7: pm_hit is 1 when the PM window is enabled and io_addr[15:7] equals PM base bits 15:7. pm_off then carries io_addr[6:0].
- R8: The SMBus window hits when it is enabled and io_addr[15:4] equals SMBus base bits 15:4. smb_off then carries io_addr[3:0].
- R9: When both windows match the same address, pm_hit is 1 and smb_hit is forced to 0.
- R10: The decode outputs still reflect the old configuration in the cycle that carries a write. They reflect the new contents from the cycle after the clock edge that accepts the write.
- R11: Writes to any other dword index change no register. Reads of any other dword index return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_dw | input | 6 | Dword index of the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_wr_be | input | 4 | Byte-lane enables of the write |
| cfg_rd_dw | input | 6 | Dword index to read |
| cfg_rd_data | output | 32 | Read data, combinational |
| io_addr | input | ADDR_W (16) | I/O address to decode |
| pm_hit | output | 1 | Address falls in the PM window |
| pm_off | output | PM_ALIGN (7) | Offset inside the PM window |
| smb_hit | output | 1 | Address falls in the SMBus window |
| smb_off | output | SMB_ALIGN (4) | Offset inside the SMBus window |

## Verification
The bench uses the default parameters: a 16-bit I/O address, 7-bit PM alignment and 4-bit SMBus alignment. With these values the whole 65,536-address I/O space is small enough to sweep completely. Every address is compared against an arithmetic model after reset, with each window enabled alone, with the PM enable bit cleared, and with the two windows overlapping. Base writes are also swept over 256 data patterns and several lane combinations.

// File: rtl/pmsmb_pkg.sv
package pmsmb_pkg;

    localparam int CFG_DW_W = 6;
    typedef logic [CFG_DW_W-1:0] cfg_dw_t;

    // dword indices and byte lanes of the owned fields
    localparam cfg_dw_t PM_EN_DW    = 6'h10;
    localparam cfg_dw_t PM_BASE_DW  = 6'h12;
    localparam cfg_dw_t SMB_BASE_DW = 6'h24;
    localparam cfg_dw_t SMB_EN_DW   = 6'h34;
    localparam int      PM_EN_LANE  = 1;
    localparam int      SMB_EN_LANE = 2;
    localparam int      PM_GATE_BIT  = 7;
    localparam int      SMB_GATE_BIT = 0;
    localparam logic [7:0] SMB_EN_KEEP = 8'h0F;
    localparam logic [7:0] PM_EN_KEEP  = 8'hFF;

    typedef struct packed {
        logic        en;
        cfg_dw_t     dw;
        logic [31:0] data;
        logic [3:0]  be;
    } cfg_wr_t;

    function automatic logic [31:0] merge_lanes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [3:0]  be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] fix_base(input logic [31:0] v,
                                             input int align,
                                             input int aw);
        logic [31:0] r;
        for (int i = 0; i < 32; i++)
            r[i] = (i >= align && i < aw) ? v[i] : 1'b0;
        r[0] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/pmsmb_base_reg.sv
module pmsmb_base_reg
    import pmsmb_pkg::*;
#(
    parameter int ALIGN  = 7,
    parameter int ADDR_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic [3:0]  be,
    input  logic [31:0] din,
    output logic [31:0] base_q
);
    localparam logic [31:0] RESET_VAL = 32'h1;

    always_ff @(posedge clk) begin
        if (rst)
            base_q <= RESET_VAL;
        else if (sel)
            base_q <= fix_base(merge_lanes(base_q, din, be), ALIGN, ADDR_W);
    end

    // R4
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(base_q));

    // R2 R3
    base_low_chk: assert property (@(posedge clk) disable iff (rst)
        sel |=> (base_q[ALIGN-1:0] == 1) && (base_q[31:ADDR_W] == 0));

endmodule

// File: rtl/pmsmb_en_reg.sv
module pmsmb_en_reg #(
    parameter logic [7:0] KEEP = 8'hFF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic [7:0] din,
    output logic [7:0] en_q
);
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 8'h00;
        else if (sel)
            en_q <= din & KEEP;
    end

    // R6
    en_keep_chk: assert property (@(posedge clk) disable iff (rst)
        sel |=> ((en_q & ~KEEP) == 8'h00));

    // R11
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(en_q));

endmodule

// File: rtl/pmsmb_win_match.sv
module pmsmb_win_match #(
    parameter int ADDR_W = 16,
    parameter int ALIGN  = 7
) (
    input  logic                    enable,
    input  logic [ADDR_W-ALIGN-1:0] base_tag,
    input  logic [ADDR_W-1:0]       io_addr,
    output logic                    hit,
    output logic [ALIGN-1:0]        off
);
    always_comb begin
        hit = enable && (io_addr[ADDR_W-1:ALIGN] == base_tag);
        off = io_addr[ALIGN-1:0];
    end
endmodule

// File: rtl/pmsmb_window_decode.sv
module pmsmb_window_decode
    import pmsmb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PM_ALIGN  = 7,
    parameter int SMB_ALIGN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_en,
    input  logic [5:0]           cfg_wr_dw,
    input  logic [31:0]          cfg_wr_data,
    input  logic [3:0]           cfg_wr_be,
    input  logic [5:0]           cfg_rd_dw,
    output logic [31:0]          cfg_rd_data,
    input  logic [ADDR_W-1:0]    io_addr,
    output logic                 pm_hit,
    output logic [PM_ALIGN-1:0]  pm_off,
    output logic                 smb_hit,
    output logic [SMB_ALIGN-1:0] smb_off
);
    localparam int PM_TAG_W  = ADDR_W - PM_ALIGN;
    localparam int SMB_TAG_W = ADDR_W - SMB_ALIGN;

    cfg_wr_t wr;
    always_comb begin
        wr.en   = cfg_wr_en;
        wr.dw   = cfg_wr_dw;
        wr.data = cfg_wr_data;
        wr.be   = cfg_wr_be;
    end

    logic [31:0] pm_base_q, smb_base_q;
    logic [7:0]  pm_en_q, smb_en_q;
    logic        sel_pm_base, sel_smb_base, sel_pm_en, sel_smb_en;

    always_comb begin
        sel_pm_base  = wr.en && (wr.dw == PM_BASE_DW)  && (|wr.be);
        sel_smb_base = wr.en && (wr.dw == SMB_BASE_DW) && (|wr.be);
        sel_pm_en    = wr.en && (wr.dw == PM_EN_DW)    && wr.be[PM_EN_LANE];
        sel_smb_en   = wr.en && (wr.dw == SMB_EN_DW)   && wr.be[SMB_EN_LANE];
    end

    pmsmb_base_reg #(.ALIGN(PM_ALIGN), .ADDR_W(ADDR_W)) u_pm_base (
        .clk(clk), .rst(rst), .sel(sel_pm_base), .be(wr.be),
        .din(wr.data), .base_q(pm_base_q));

    pmsmb_base_reg #(.ALIGN(SMB_ALIGN), .ADDR_W(ADDR_W)) u_smb_base (
        .clk(clk), .rst(rst), .sel(sel_smb_base), .be(wr.be),
        .din(wr.data), .base_q(smb_base_q));

    pmsmb_en_reg #(.KEEP(PM_EN_KEEP)) u_pm_en (
        .clk(clk), .rst(rst), .sel(sel_pm_en),
        .din(wr.data[PM_EN_LANE*8 +: 8]), .en_q(pm_en_q));

    pmsmb_en_reg #(.KEEP(SMB_EN_KEEP)) u_smb_en (
        .clk(clk), .rst(rst), .sel(sel_smb_en),
        .din(wr.data[SMB_EN_LANE*8 +: 8]), .en_q(smb_en_q));

    logic pm_match, smb_match;

    pmsmb_win_match #(.ADDR_W(ADDR_W), .ALIGN(PM_ALIGN)) u_pm_match (
        .enable(pm_en_q[PM_GATE_BIT]),
        .base_tag(pm_base_q[ADDR_W-1:PM_ALIGN]),
        .io_addr(io_addr), .hit(pm_match), .off(pm_off));

    pmsmb_win_match #(.ADDR_W(ADDR_W), .ALIGN(SMB_ALIGN)) u_smb_match (
        .enable(smb_en_q[SMB_GATE_BIT]),
        .base_tag(smb_base_q[ADDR_W-1:SMB_ALIGN]),
        .io_addr(io_addr), .hit(smb_match), .off(smb_off));

    // PM wins on overlap
    always_comb begin
        pm_hit  = pm_match;
        smb_hit = smb_match && !pm_match;
    end

    always_comb begin
        cfg_rd_data = 32'h0;
        case (cfg_rd_dw)
            PM_EN_DW:    cfg_rd_data[PM_EN_LANE*8 +: 8]  = pm_en_q;
            PM_BASE_DW:  cfg_rd_data = pm_base_q;
            SMB_BASE_DW: cfg_rd_data = smb_base_q;
            SMB_EN_DW:   cfg_rd_data[SMB_EN_LANE*8 +: 8] = smb_en_q;
            default:     cfg_rd_data = 32'h0;
        endcase
    end

    // R9
    one_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !(pm_hit && smb_hit));

    // R5
    pm_hit_gate_chk: assert property (@(posedge clk) disable iff (rst)
        pm_hit |-> pm_en_q[PM_GATE_BIT]);

    // R6
    smb_hit_gate_chk: assert property (@(posedge clk) disable iff (rst)
        smb_hit |-> smb_en_q[SMB_GATE_BIT]);

endmodule

// File: tb/sim_pmsmb_window_decode.sv
module sim_pmsmb_window_decode;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_wr_dw = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [3:0]  cfg_wr_be = '0;
    logic [5:0]  cfg_rd_dw = '0;
    logic [31:0] cfg_rd_data;
    logic [15:0] io_addr = '0;
    logic        pm_hit, smb_hit;
    logic [6:0]  pm_off;
    logic [3:0]  smb_off;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // model state
    logic [31:0] m_pm = 32'h1, m_smb = 32'h1;
    logic [7:0]  m_pm_en = 8'h0, m_smb_en = 8'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmsmb_window_decode u0 (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_dw(cfg_wr_dw),
        .cfg_wr_data(cfg_wr_data), .cfg_wr_be(cfg_wr_be), .cfg_rd_dw(cfg_rd_dw),
        .cfg_rd_data(cfg_rd_data), .io_addr(io_addr), .pm_hit(pm_hit),
        .pm_off(pm_off), .smb_hit(smb_hit), .smb_off(smb_off));

    function automatic logic [31:0] mrg(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? n[i*8 +: 8] : o[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(logic [5:0] dw, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_dw = dw; cfg_wr_data = d; cfg_wr_be = be;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (be != 0) begin
            if (dw == 6'h12) m_pm  = (mrg(m_pm,  d, be) & 32'hFF80) | 32'h1;
            if (dw == 6'h24) m_smb = (mrg(m_smb, d, be) & 32'hFFF0) | 32'h1;
        end
        if (dw == 6'h10 && be[1]) m_pm_en  = d[15:8];
        if (dw == 6'h34 && be[2]) m_smb_en = d[23:16] & 8'h0F;
    endtask

    task automatic rd(string req, logic [5:0] dw, logic [31:0] exp);
        cfg_rd_dw = dw; #1;
        chk(req, cfg_rd_data, exp);
    endtask

    // sweep the full I/O space against the model, one check per sweep
    task automatic sweep(string req);
        int bad = 0;
        logic [31:0] fa = 0, fe = 0;
        for (int a = 0; a < 65536; a++) begin
            logic ep, es;
            logic [31:0] act, exp;
            io_addr = a[15:0]; #1;
            ep = m_pm_en[7] && (a[15:7] == m_pm[15:7]);
            es = m_smb_en[0] && (a[15:4] == m_smb[15:4]) && !ep;
            exp = {18'b0, ep, es, a[6:0], a[3:0]};
            act = {18'b0, pm_hit, smb_hit, pm_off, smb_off};
            if (act !== exp) begin
                if (bad == 0) begin fa = act; fe = exp; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s sweep mismatches=%0d actual=%h expected=%h", req, bad, fa, fe);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd("R1", 6'h12, 32'h1);
        rd("R1", 6'h24, 32'h1);
        rd("R1", 6'h10, 32'h0);
        rd("R1", 6'h34, 32'h0);
        sweep("R1");

        // R2 PM base correction over many patterns
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b = i[7:0];
            cfg_wr(6'h12, {b, b ^ 8'h5A, ~b, b}, 4'hF);
            rd("R2", 6'h12, m_pm);
        end
        // R3 SMBus base correction
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b = i[7:0];
            cfg_wr(6'h24, {~b, b, b ^ 8'hC3, b}, 4'hF);
            rd("R3", 6'h24, m_smb);
        end
        // R4 partial lanes
        cfg_wr(6'h12, 32'h0000_1200, 4'hF);
        rd("R4", 6'h12, 32'h0000_1201);
        cfg_wr(6'h12, 32'hFFFF_FFFF, 4'b0001);
        rd("R4", 6'h12, 32'h0000_1281);
        cfg_wr(6'h12, 32'h0000_AB00, 4'b0010);
        rd("R4", 6'h12, 32'h0000_AB81);
        cfg_wr(6'h24, 32'hFFFF_FFFF, 4'b0000);
        rd("R4", 6'h24, m_smb);

        // R11 other dwords
        cfg_wr(6'h11, 32'hFFFF_FFFF, 4'hF);
        cfg_wr(6'h25, 32'hFFFF_FFFF, 4'hF);
        cfg_wr(6'h35, 32'hFFFF_FFFF, 4'hF);
        rd("R11", 6'h12, 32'h0000_AB81);
        rd("R11", 6'h24, m_smb);
        rd("R11", 6'h10, 32'h0);
        rd("R11", 6'h34, 32'h0);
        rd("R11", 6'h11, 32'h0);
        rd("R11", 6'h35, 32'h0);

        // R5 PM enable byte, bit 7 clear keeps window off
        cfg_wr(6'h10, 32'hFFFF_7FFF, 4'b0010);
        rd("R5", 6'h10, 32'h0000_7F00);
        sweep("R5");
        // R7 PM only
        cfg_wr(6'h10, 32'h0000_8000, 4'b0010);
        rd("R5", 6'h10, 32'h0000_8000);
        sweep("R7");
        // R6 SMBus enable nibble
        cfg_wr(6'h34, 32'hFFFF_FFFF, 4'b0100);
        rd("R6", 6'h34, 32'h000F_0000);
        cfg_wr(6'h10, 32'h0, 4'b0010);
        cfg_wr(6'h24, 32'h0000_2C4F, 4'b0011);
        rd("R3", 6'h24, 32'h0000_2C41);
        sweep("R8");
        cfg_wr(6'h34, 32'h00FE_0000, 4'b0100);
        rd("R6", 6'h34, 32'h000E_0000);
        sweep("R6");
        // R9 overlap
        cfg_wr(6'h34, 32'h0001_0000, 4'b0100);
        cfg_wr(6'h10, 32'h0000_8000, 4'b0010);
        cfg_wr(6'h12, 32'h0000_1000, 4'hF);
        cfg_wr(6'h24, 32'h0000_1010, 4'hF);
        io_addr = 16'h1013; #1;
        chk("R9", {30'b0, pm_hit, smb_hit}, 32'h2);
        sweep("R9");

        // R10 timing of a write versus decode
        io_addr = 16'h1013;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_dw = 6'h10; cfg_wr_data = 32'h0; cfg_wr_be = 4'b0010;
        #1;
        chk("R10", {30'b0, pm_hit, smb_hit}, 32'h2);
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
        chk("R10", {30'b0, pm_hit, smb_hit}, 32'h1);
        m_pm_en = 8'h0;
        chk("R10", {25'b0, pm_off}, 32'h13);

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule